// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Output-Enable Lane

This block takes a parallel word on a slow divided clock and sends it as a serial stream on a fast clock. The two clocks are phase aligned. A second serial lane runs alongside the data lane and carries output-enable bits, so a pad driver gets each data bit and its matching enable at the same instant. Word width is 2 to 8 bits. In single-rate mode one bit leaves per fast cycle. In double-rate mode two bits leave per fast cycle: the lower-numbered bit while the fast clock is high, the next one while it is low.

A beat counter in the fast domain tells both lanes which slice of the captured word to send. The counter period equals one divided-clock period. The next word is captured while the current one is still going out, so the stream has no gaps. Reset is synchronous. It must be released so that the first fast edge that sees it low is also a divided-clock rising edge. Separate reset levels and idle levels are set for each output. Separate clock enables freeze each output register without stopping the stream underneath.

Top module: `ptos_tx`

## Requirements
- R1: Input bit `d_par[0]` is sent first, then `d_par[1]`, and so on up to `d_par[WIDTH-1]`.
- R2: Single-rate mode sends one bit per fast cycle. Bit 0 of a word captured at divided-clock edge E is on `d_ser` after the first fast edge that follows E.
- R3: Double-rate mode sends two bits per fast cycle, the even-indexed bit while `clk_ser` is high and the odd-indexed bit while it is low. The first pair of a word captured at edge E appears one divided period (WIDTH/2 fast cycles) after E, which is 4 fast cycles for width 8.
- R4: Consecutive words follow each other with no idle bits. The beat counter stays below the number of fast cycles per divided period.
- R5: With an enable width of 1, `t_par[0]` of a word is sent on `t_ser` for every bit of that word, with the same timing as the data.
- R6: With an enable width of 4, `t_par[j]` covers data bits j*WIDTH/4 up to (j+1)*WIDTH/4-1, and each enable leaves at the same instant as its data bit. A low enable means the pad is driven.
- R7: While reset is asserted, `d_ser` equals `RST_D` and `t_ser` equals `RST_T`.
- R8: After reset is released and before the first captured word appears, `d_ser` shows `INIT_D` and `t_ser` shows `INIT_T`.
- R9: While `d_ce` is low, the data output register holds its value. Capture and sequencing continue, so the stream resumes at its current position when `d_ce` returns high.
- R10: `t_ce` freezes the enable output register in the same way as R9, and it does not affect the data lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast serial clock |
| clk_par | input | 1 | Divided parallel clock, phase aligned with `clk_ser` |
| rst | input | 1 | Synchronous reset, active high |
| d_ce | input | 1 | Data output register enable |
| t_ce | input | 1 | Enable-lane output register enable |
| d_par | input | WIDTH | Parallel data word |
| t_par | input | TW | Parallel output-enable bits (low = drive) |
| d_ser | output | 1 | Serial data |
| t_ser | output | 1 | Serial tristate control |

## Verification
The bench builds four variants: 2-bit single-rate with one enable, 8-bit double-rate with four enables, 4-bit single-rate with four enables, and 6-bit double-rate with one enable. Together they cover the shortest single-rate latency, the 8:1 double-rate latency of four fast cycles, one-to-one and two-bit enable grouping, and an odd beat count. In each variant the fast output is sampled in both clock phases against a stream built from the stimulus table. The variants also run through the reset level, the idle level, and separate freeze windows for each lane.

// File: rtl/ptos_pkg.sv
package ptos_pkg;
  timeunit 1ns; timeprecision 1ps;

  // fast cycles in one divided-clock period
  function automatic int beats_of(int width, bit ddr);
    return ddr ? width / 2 : width;
  endfunction

  function automatic int cnt_bits(int beats);
    return (beats <= 1) ? 1 : $clog2(beats);
  endfunction

  function automatic int idx_bits(int width);
    return (width <= 2) ? 1 : $clog2(width);
  endfunction

  // which enable bit governs data bit bit_i
  function automatic int en_group(int bit_i, int width, int tw);
    return (tw == 1) ? 0 : bit_i / (width / 4);
  endfunction

  // single-rate: bit sent at beat c (beat 0 finishes the previous word)
  function automatic int sdr_pick(int c, int width);
    return (c == 0) ? width - 1 : c - 1;
  endfunction
endpackage

// File: rtl/ptos_beat_ctr.sv
module ptos_beat_ctr #(
  parameter int BEATS = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (cnt == CW'(BEATS - 1))   cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ptos_lane.sv
module ptos_lane #(
  parameter int   WIDTH = 8,
  parameter bit   DDR   = 1'b1,
  parameter int   CW    = 2,
  parameter int   PW    = 2,
  parameter logic RST_V = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [CW-1:0]    cnt,
  input  logic [WIDTH-1:0] word,
  output logic [PW-1:0]    pair
);
  timeunit 1ns; timeprecision 1ps;
  localparam int IW = ptos_pkg::idx_bits(WIDTH);

  generate
    if (DDR) begin : g_ddr
      logic [WIDTH-1:0] shadow;
      logic [IW-1:0]    base;
      assign base = IW'(2 * int'(cnt));
      always_ff @(posedge clk) begin
        if (rst) begin
          pair   <= {PW{RST_V}};
          shadow <= '0;
        end else begin
          if (cnt == '0) shadow <= word;
          if (ce) pair <= (cnt == '0) ? word[1:0] : shadow[base +: 2];
        end
      end
    end else begin : g_sdr
      logic [IW-1:0] pick;
      assign pick = IW'(ptos_pkg::sdr_pick(int'(cnt), WIDTH));
      always_ff @(posedge clk) begin
        if (rst)     pair <= {PW{RST_V}};
        else if (ce) pair <= word[pick];
      end
    end
  endgenerate
endmodule

// File: rtl/ptos_tx.sv
module ptos_tx #(
  parameter int   WIDTH  = 8,
  parameter bit   DDR    = 1'b1,
  parameter int   TW     = 4,
  parameter logic RST_D  = 1'b0,
  parameter logic RST_T  = 1'b1,
  parameter logic INIT_D = 1'b0,
  parameter logic INIT_T = 1'b1
) (
  input  logic             clk_ser,
  input  logic             clk_par,
  input  logic             rst,
  input  logic             d_ce,
  input  logic             t_ce,
  input  logic [WIDTH-1:0] d_par,
  input  logic [TW-1:0]    t_par,
  output logic             d_ser,
  output logic             t_ser
);
  timeunit 1ns; timeprecision 1ps;
  localparam int BEATS = ptos_pkg::beats_of(WIDTH, DDR);
  localparam int CW    = ptos_pkg::cnt_bits(BEATS);
  localparam int PW    = DDR ? 2 : 1;

  logic [WIDTH-1:0] d_q;
  logic [TW-1:0]    t_q;
  logic [WIDTH-1:0] t_word;
  logic [CW-1:0]    beat_cnt;
  logic [PW-1:0]    d_pair, t_pair;

  // divided-clock capture; idle level loaded at reset
  always_ff @(posedge clk_par) begin
    if (rst) begin
      d_q <= {WIDTH{INIT_D}};
      t_q <= {TW{INIT_T}};
    end else begin
      d_q <= d_par;
      t_q <= t_par;
    end
  end

  // spread enable bits over the data bit positions they govern
  for (genvar i = 0; i < WIDTH; i++) begin : g_exp
    assign t_word[i] = t_q[ptos_pkg::en_group(i, WIDTH, TW)];
  end

  ptos_beat_ctr #(.BEATS(BEATS), .CW(CW)) u_ctr (
    .clk(clk_ser), .rst(rst), .cnt(beat_cnt)
  );

  ptos_lane #(.WIDTH(WIDTH), .DDR(DDR), .CW(CW), .PW(PW), .RST_V(RST_D)) u_dlane (
    .clk(clk_ser), .rst(rst), .ce(d_ce), .cnt(beat_cnt), .word(d_q), .pair(d_pair)
  );

  ptos_lane #(.WIDTH(WIDTH), .DDR(DDR), .CW(CW), .PW(PW), .RST_V(RST_T)) u_tlane (
    .clk(clk_ser), .rst(rst), .ce(t_ce), .cnt(beat_cnt), .word(t_word), .pair(t_pair)
  );

  generate
    if (DDR) begin : g_out_ddr
      assign d_ser = clk_ser ? d_pair[0] : d_pair[PW-1];
      assign t_ser = clk_ser ? t_pair[0] : t_pair[PW-1];
    end else begin : g_out_sdr
      assign d_ser = d_pair[0];
      assign t_ser = t_pair[0];
    end
  endgenerate
endmodule

// File: rtl/ptos_tx_chk.sv
module ptos_tx_chk #(
  parameter int   BEATS = 4,
  parameter int   CW    = 2,
  parameter int   PW    = 2,
  parameter logic RST_D = 1'b0,
  parameter logic RST_T = 1'b1
) (
  input logic          clk_ser,
  input logic          rst,
  input logic          d_ce,
  input logic          t_ce,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] d_pair,
  input logic [PW-1:0] t_pair
);
  timeunit 1ns; timeprecision 1ps;

  logic rst_seen = 1'b0;

  always_ff @(posedge clk_ser) begin
    rst_seen <= rst;
    if (rst_seen) begin
      a_r7_data_rst_level: assert (d_pair == {PW{RST_D}})
        else $error("data lane not at reset level");
      a_r7_en_rst_level: assert (t_pair == {PW{RST_T}})
        else $error("enable lane not at reset level");
    end
  end

  a_r4_beat_range: assert property (@(posedge clk_ser) disable iff (rst)
    int'(cnt) < BEATS);

  a_r9_data_hold: assert property (@(posedge clk_ser) disable iff (rst)
    !d_ce |=> $stable(d_pair));

  a_r10_en_hold: assert property (@(posedge clk_ser) disable iff (rst)
    !t_ce |=> $stable(t_pair));
endmodule

bind ptos_tx ptos_tx_chk #(
  .BEATS(BEATS), .CW(CW), .PW(PW), .RST_D(RST_D), .RST_T(RST_T)
) u_chk (
  .clk_ser(clk_ser), .rst(rst), .d_ce(d_ce), .t_ce(t_ce),
  .cnt(beat_cnt), .d_pair(d_pair), .t_pair(t_pair)
);

// File: tb/ptos_tx_tb_top.sv
module ptos_cfg_tb #(
  parameter int W   = 8,
  parameter bit DDR = 1'b1,
  parameter int TW  = 4,
  parameter int OFS = 0
) (
  output logic done,
  output int   n_chk,
  output int   n_fail
);
  timeunit 1ns; timeprecision 1ps;
  localparam int B     = DDR ? W / 2 : W;
  localparam int KMAX  = 14 * B + 4;
  localparam int DCE0  = 2 * B + 1;
  localparam int TCE0  = 5 * B + 2;
  localparam logic RD = 1'b1, RT = 1'b0, ID = 1'b0, IT = 1'b1;
  // [7:0] data, [11:8] enables
  localparam logic [11:0] VEC [16] = '{
    12'h0A5, 12'hF3C, 12'h55A, 12'h0FF, 12'hA00, 12'h381, 12'hC7E, 12'h166,
    12'h9D2, 12'h2B4, 12'hE19, 12'h4C3, 12'h7F0, 12'hB0F, 12'h6AA, 12'hD57};

  logic clk_ser = 1'b0, clk_par = 1'b0, rst = 1'b1, d_ce = 1'b1, t_ce = 1'b1;
  logic [W-1:0]  d_par = '0;
  logic [TW-1:0] t_par = '0;
  logic d_ser, t_ser;

  ptos_tx #(.WIDTH(W), .DDR(DDR), .TW(TW), .RST_D(RD), .RST_T(RT),
            .INIT_D(ID), .INIT_T(IT)) dut_i (
    .clk_ser(clk_ser), .clk_par(clk_par), .rst(rst), .d_ce(d_ce), .t_ce(t_ce),
    .d_par(d_par), .t_par(t_par), .d_ser(d_ser), .t_ser(t_ser));

  // 100 MHz fast clock; divided clock rises with every B-th fast edge
  initial begin
    int kc = 0;
    forever begin
      #5 clk_ser = 1'b1; clk_par = (kc % B) < ((B + 1) / 2); kc++;
      #5 clk_ser = 1'b0; if (B == 1) clk_par = 1'b0;
    end
  end

  function automatic logic dbit(int s);
    logic [11:0] v;
    if (s < 0) return ID;
    v = VEC[((s / W) + OFS) % 16];
    return v[s % W];
  endfunction

  function automatic logic tbit(int s);
    logic [11:0] v;
    int g;
    if (s < 0) return IT;
    v = VEC[((s / W) + OFS) % 16];
    g = (TW == 1) ? 0 : ((s % W) * 4) / W;
    return v[8 + g];
  endfunction

  task automatic drive_word(int n);
    logic [11:0] v;
    v = VEC[(n + OFS) % 16];
    d_par = v[W-1:0];
    t_par = v[8 +: TW];
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (W=%0d DDR=%0d TW=%0d): actual %b expected %b",
               tag, W, DDR, TW, act, exp);
    end
  endtask

  initial begin
    logic ed_hi, ed_lo, et_hi, et_lo, cur_dce, cur_tce;
    string dtag, ttag;
    int s;
    done = 1'b0; n_chk = 0; n_fail = 0;
    ed_hi = ID; ed_lo = ID; et_hi = IT; et_lo = IT;
    dtag = ""; ttag = "";
    repeat (2 * B + 3) @(posedge clk_ser);
    #2;
    chk("R7 data reset level", d_ser, RD);
    chk("R7 enable reset level", t_ser, RT);
    #5;
    chk("R7 data reset level low phase", d_ser, RD);
    chk("R7 enable reset level low phase", t_ser, RT);
    // release so the first low-sampling fast edge is a divided edge
    @(posedge clk_par);
    repeat (B - 1) @(posedge clk_ser);
    #1 rst = 1'b0;
    drive_word(0);
    cur_dce = 1'b1; cur_tce = 1'b1;
    for (int k = 0; k < KMAX; k++) begin
      @(posedge clk_ser);
      s = DDR ? 2 * (k - B) : k - 1;
      if (cur_dce) begin
        ed_hi = dbit(s);
        ed_lo = DDR ? dbit(s + 1) : dbit(s);
        dtag = (s < 0) ? "R8 data idle level" :
               (DDR ? "R1 R3 R4 data order and latency" : "R1 R2 R4 data order and latency");
      end else dtag = "R9 data held by d_ce";
      if (cur_tce) begin
        et_hi = tbit(s);
        et_lo = DDR ? tbit(s + 1) : tbit(s);
        ttag = (s < 0) ? "R8 enable idle level" :
               ((TW == 1) ? "R5 enable spans word" : "R6 enable group aligned");
      end else ttag = "R10 enable held by t_ce";
      #1;
      if (k % B == 0) drive_word(k / B + 1);
      cur_dce = !((k + 1 >= DCE0) && (k + 1 < DCE0 + 3));
      cur_tce = !((k + 1 >= TCE0) && (k + 1 < TCE0 + 3));
      d_ce = cur_dce; t_ce = cur_tce;
      #2;
      chk(dtag, d_ser, ed_hi);
      chk(ttag, t_ser, et_hi);
      #5;
      chk(dtag, d_ser, ed_lo);
      chk(ttag, t_ser, et_lo);
    end
    done = 1'b1;
  end
endmodule

module ptos_tx_tb_top;
  timeunit 1ns; timeprecision 1ps;
  logic dn_a, dn_b, dn_c, dn_d;
  int   ch_a, ch_b, ch_c, ch_d, fl_a, fl_b, fl_c, fl_d;

  ptos_cfg_tb #(.W(2), .DDR(1'b0), .TW(1), .OFS(0))  u_sdr2 (.done(dn_a), .n_chk(ch_a), .n_fail(fl_a));
  ptos_cfg_tb #(.W(8), .DDR(1'b1), .TW(4), .OFS(3))  u_ddr8 (.done(dn_b), .n_chk(ch_b), .n_fail(fl_b));
  ptos_cfg_tb #(.W(4), .DDR(1'b0), .TW(4), .OFS(7))  u_sdr4 (.done(dn_c), .n_chk(ch_c), .n_fail(fl_c));
  ptos_cfg_tb #(.W(6), .DDR(1'b1), .TW(1), .OFS(11)) u_ddr6 (.done(dn_d), .n_chk(ch_d), .n_fail(fl_d));

  initial begin
    int total, bad;
    bit timed_out;
    timed_out = 1'b0;
    fork
      wait (dn_a && dn_b && dn_c && dn_d);
      begin #1000000; timed_out = 1'b1; end
    join_any
    disable fork;
    total = ch_a + ch_b + ch_c + ch_d;
    bad   = fl_a + fl_b + fl_c + fl_d;
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected all variants done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", total, bad);
    $finish;
  end
endmodule